// File: doc/BRIEF.md
# Host Controller Run/Stop/Reset Sequencer

This block is the command and status core of a USB host controller. Software writes a command word holding three control bits: run, controller reset and interrupt enable. It reads back a status word whose event bits are cleared by writing 1. A four-state sequencer steps through halted, running, draining and resetting. It drives a halted flag, a reset level that holds the rest of the controller in reset, and a gated interrupt request.

Stopping is a handshake with an abstract schedule engine. After run is cleared, the block waits for the engine to report that its queued work has drained, or to report that no work is pending. A cycle-count timeout forces the halt when neither happens. Reset may be started only while halted. It lasts a fixed number of cycles, clears itself and cannot be cut short. Interrupt requests leave the block only at threshold ticks, and only while they are enabled.

Top module: `hc_runctl`

## Requirements
- R1: After power-on reset, halted is 1, the command word reads 0, the status word reads 1 (only its halted bit, bit 0, set), and irq and ctrl_rst are 0.
- R2: A command write (offset 0x80) with bit 0 = 1 while halted starts the controller: from the next cycle halted is 0 and command bit 0 reads 1. The same write made while draining is ignored.
- R3: A command write with bit 0 = 0 while running enters draining: halted stays 0 and command bit 0 reads 0. Halted becomes 1 one cycle after a clock edge at which drain_done is 1 or pend_work is 0.
- R4: If draining does not complete, the block halts exactly DRAIN_TMO cycles after the stop write and sets status bit 3 (drain timeout).
- R5: A command write with bit 1 = 1 while halted enters reset. For RST_CYC cycles, ctrl_rst is 1 and command bit 1 reads 1. The status event bits and the interrupt enable are cleared. Afterwards the block is halted with the command word at 0.
- R6: While reset is in progress, every register write is ignored, including a write of 0 to command bit 1.
- R7: A command write with bit 1 = 1 while not halted does not start a reset and sets status bit 1 (illegal reset).
- R8: Status bits 1 to 3 are cleared by a write (offset 0x84) with a 1 in their position. A 0 leaves them unchanged, and bit 0 cannot be written. An event that arrives in the same cycle as its clearing write wins. evt_in sets status bit 2.
- R9: irq pulses for one cycle after a clock edge at which thresh is 1, interrupt enable (command bit 2) is 1 and status bit 2 is set. With enable at 0, no pulse occurs.
- R10: A run write while already running changes nothing. A write with both bit 0 and bit 1 set while halted performs the reset only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register write offset |
| reg_wdata | input | DATA_W | Register write data |
| cmd_rdata | output | DATA_W | Command word read value |
| sts_rdata | output | DATA_W | Status word read value |
| pend_work | input | 1 | Schedule engine still has queued work |
| drain_done | input | 1 | Schedule engine finished its queued work |
| evt_in | input | 1 | Interrupt-worthy event from the controller |
| thresh | input | 1 | Interrupt threshold tick |
| halted | output | 1 | Controller is halted |
| ctrl_rst | output | 1 | Reset level for the rest of the controller |
| irq | output | 1 | Interrupt request pulse |

## Verification
Two pairs of events can fall in the same cycle. In the first, a software write that clears the event bit meets a new event. The bench drives evt_in high on the very edge that samples a write-1-to-clear of status bit 2, and expects the bit to stay set. In the second, a run request meets a reset request: a single command write carries both bit 0 and bit 1 while halted, and the bench expects the reset to happen alone, with run never reading back as 1. A behavioural reference model, stepped on every clock edge, judges both cases together with all other outputs.

// File: rtl/hc_runctl_pkg.sv
package hc_runctl_pkg;

   typedef enum logic [1:0] {
      ST_HALT  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2,
      ST_RESET = 2'd3
   } hc_state_e;

   // command word bit positions
   localparam int CB_RUN = 0;
   localparam int CB_RST = 1;
   localparam int CB_IE  = 2;

   // status word bit positions
   localparam int SB_HALT = 0;
   localparam int SB_RERR = 1;
   localparam int SB_EVT  = 2;
   localparam int SB_TMO  = 3;

   // index of each event flag inside the status flag vector
   localparam int FL_RERR = 0;
   localparam int FL_EVT  = 1;
   localparam int FL_TMO  = 2;
   localparam int FL_N    = 3;

endpackage

// File: rtl/hc_runctl_seq.sv
module hc_runctl_seq
   import hc_runctl_pkg::*;
#(
   parameter int DRAIN_TMO = 64,
   parameter int RST_CYC   = 8
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      go_run,
   input  logic      go_stop,
   input  logic      go_reset,
   input  logic      drain_done,
   input  logic      pend_work,
   output hc_state_e state,
   output logic      tmo_hit
);

   localparam int CMAX = (DRAIN_TMO > RST_CYC) ? DRAIN_TMO : RST_CYC;
   localparam int CW   = $clog2(CMAX + 1);
   localparam logic [CW-1:0] TMO_LAST = CW'(DRAIN_TMO - 1);
   localparam logic [CW-1:0] RST_LAST = CW'(RST_CYC - 1);

   generate
      if (DRAIN_TMO < 1) begin : g_bad_tmo
         $error("DRAIN_TMO must be at least 1");
      end
      if (RST_CYC < 1) begin : g_bad_rst
         $error("RST_CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          drained;

   assign drained = drain_done || !pend_work;
   assign tmo_hit = (state == ST_DRAIN) && !drained && (cnt == TMO_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_HALT;
         cnt   <= '0;
      end else begin
         unique case (state)
            ST_HALT: begin
               cnt <= '0;
               if (go_reset)    state <= ST_RESET;
               else if (go_run) state <= ST_RUN;
            end
            ST_RUN: begin
               if (go_stop) begin
                  state <= ST_DRAIN;
                  cnt   <= '0;
               end
            end
            ST_DRAIN: begin
               if (drained || cnt == TMO_LAST) begin
                  state <= ST_HALT;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_RESET: begin
               if (cnt == RST_LAST) begin
                  state <= ST_HALT;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= ST_HALT;
         endcase
      end
   end

   // R4: draining never outlives its window
   p_drain_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DRAIN) |-> (cnt <= TMO_LAST));

   // R2: running is entered only from halted
   p_run_from_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && $past(state) != ST_RUN) |-> ($past(state) == ST_HALT));

   // R5: reset is entered only from halted
   p_reset_from_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RESET && $past(state) != ST_RESET) |-> ($past(state) == ST_HALT));

   // R5: reset always ends in halted
   p_reset_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_RESET && state != ST_RESET) |-> (state == ST_HALT));

endmodule

// File: rtl/hc_runctl_sts.sv
module hc_runctl_sts
   import hc_runctl_pkg::*;
#(
   parameter bit SET_WINS = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr_all,
   input  logic            wr_en,
   input  logic [FL_N-1:0] clr_mask,
   input  logic [FL_N-1:0] set_vec,
   input  logic            ie,
   input  logic            thresh,
   output logic [FL_N-1:0] flags,
   output logic            irq
);

   for (genvar i = 0; i < FL_N; i++) begin : g_flag
      logic clr;
      assign clr = wr_en && clr_mask[i];
      if (SET_WINS) begin : g_set_wins
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       flags[i] <= 1'b0;
            else if (clr_all) flags[i] <= 1'b0;
            else              flags[i] <= set_vec[i] || (flags[i] && !clr);
         end
      end else begin : g_clr_wins
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       flags[i] <= 1'b0;
            else if (clr_all) flags[i] <= 1'b0;
            else              flags[i] <= (set_vec[i] || flags[i]) && !clr;
         end
      end

      // R8: a write of 1 with no new event leaves the flag clear
      p_rw1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (clr && !set_vec[i]) |=> !flags[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= !clr_all && ie && thresh && flags[FL_EVT];
   end

   // R9: a request only follows an enabled threshold with a pending event
   p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(ie && thresh && flags[FL_EVT]));

endmodule

// File: rtl/hc_runctl.sv
module hc_runctl
   import hc_runctl_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 32,
   parameter int CMD_OFS      = 'h80,
   parameter int STS_OFS      = 'h84,
   parameter int DRAIN_TMO    = 64,
   parameter int RST_CYC      = 8,
   parameter bit STS_SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] cmd_rdata,
   output logic [DATA_W-1:0] sts_rdata,
   input  logic              pend_work,
   input  logic              drain_done,
   input  logic              evt_in,
   input  logic              thresh,
   output logic              halted,
   output logic              ctrl_rst,
   output logic              irq
);

   localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_OFS);
   localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_OFS);

   generate
      if (DATA_W < 5) begin : g_bad_dw
         $error("DATA_W must be at least 5");
      end
      if (CMD_OFS == STS_OFS) begin : g_bad_ofs
         $error("command and status offsets must differ");
      end
      if (STS_OFS >= (1 << ADDR_W) || CMD_OFS >= (1 << ADDR_W)) begin : g_bad_aw
         $error("offsets do not fit ADDR_W");
      end
   endgenerate

   hc_state_e       state;
   logic            tmo_hit;
   logic            resetting;
   logic            cmd_wr, sts_wr;
   logic            rst_req, rst_go, rst_bad;
   logic            go_run, go_stop;
   logic            ie;
   logic [FL_N-1:0] flags, set_vec, clr_mask;
   logic            unused_wdata_hi;

   assign unused_wdata_hi = ^reg_wdata[DATA_W-1:4];

   assign resetting = (state == ST_RESET);
   assign halted    = (state == ST_HALT);
   assign ctrl_rst  = resetting;

   assign cmd_wr  = reg_we && (reg_addr == CMD_A) && !resetting;
   assign sts_wr  = reg_we && (reg_addr == STS_A) && !resetting;
   assign rst_req = cmd_wr && reg_wdata[CB_RST];
   assign rst_go  = rst_req && halted;
   assign rst_bad = rst_req && !halted;
   assign go_run  = cmd_wr && reg_wdata[CB_RUN] && !rst_go;
   assign go_stop = cmd_wr && !reg_wdata[CB_RUN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ie <= 1'b0;
      else if (rst_go || resetting) ie <= 1'b0;
      else if (cmd_wr)             ie <= reg_wdata[CB_IE];
   end

   hc_runctl_seq #(
      .DRAIN_TMO (DRAIN_TMO),
      .RST_CYC   (RST_CYC)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_run     (go_run),
      .go_stop    (go_stop),
      .go_reset   (rst_go),
      .drain_done (drain_done),
      .pend_work  (pend_work),
      .state      (state),
      .tmo_hit    (tmo_hit)
   );

   always_comb begin
      set_vec           = '0;
      set_vec[FL_RERR]  = rst_bad;
      set_vec[FL_EVT]   = evt_in;
      set_vec[FL_TMO]   = tmo_hit;
      clr_mask          = '0;
      clr_mask[FL_RERR] = reg_wdata[SB_RERR];
      clr_mask[FL_EVT]  = reg_wdata[SB_EVT];
      clr_mask[FL_TMO]  = reg_wdata[SB_TMO];
   end

   hc_runctl_sts #(
      .SET_WINS (STS_SET_WINS)
   ) u_sts (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_all  (rst_go || resetting),
      .wr_en    (sts_wr),
      .clr_mask (clr_mask),
      .set_vec  (set_vec),
      .ie       (ie),
      .thresh   (thresh),
      .flags    (flags),
      .irq      (irq)
   );

   always_comb begin
      cmd_rdata         = '0;
      cmd_rdata[CB_RUN] = (state == ST_RUN);
      cmd_rdata[CB_RST] = resetting;
      cmd_rdata[CB_IE]  = ie;
      sts_rdata          = '0;
      sts_rdata[SB_HALT] = halted;
      sts_rdata[SB_RERR] = flags[FL_RERR];
      sts_rdata[SB_EVT]  = flags[FL_EVT];
      sts_rdata[SB_TMO]  = flags[FL_TMO];
   end

   // R7: an illegal reset request never starts a reset
   p_bad_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_bad |=> !ctrl_rst);

   // R6: interrupt enable stays clear throughout reset
   p_reset_ie_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_rst |-> !cmd_rdata[CB_IE]);

   // R5: the reset level and the halted flag never overlap
   p_rst_not_halted_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_rst |-> !halted);

endmodule

// File: tb/hc_runctl_bench.sv
`timescale 1ns/1ps
module hc_runctl_bench;

   localparam int TMO = 20;
   localparam int RST = 8;
   localparam logic [7:0] A_CMD = 8'h80;
   localparam logic [7:0] A_STS = 8'h84;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] cmd_rdata, sts_rdata;
   logic        pend_work = 1'b1;
   logic        drain_done = 1'b0;
   logic        evt_in = 1'b0;
   logic        thresh = 1'b0;
   logic        halted, ctrl_rst, irq;

   always #10 clk = ~clk;

   hc_runctl #(
      .DRAIN_TMO (TMO),
      .RST_CYC   (RST)
   ) u_hc_runctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_we     (reg_we),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .cmd_rdata  (cmd_rdata),
      .sts_rdata  (sts_rdata),
      .pend_work  (pend_work),
      .drain_done (drain_done),
      .evt_in     (evt_in),
      .thresh     (thresh),
      .halted     (halted),
      .ctrl_rst   (ctrl_rst),
      .irq        (irq)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   bit    finished = 1'b0;
   string tag = "R1";

   task automatic chk(input string t, input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
      end
   endtask

   // behavioural reference: 0 halted, 1 running, 2 draining, 3 resetting
   int m_st, m_drain_el, m_rst_el;
   bit m_ie, m_err, m_evt, m_tmo, m_irq;
   bit w_cmd, w_sts, w_rgo, w_rbad, w_to, in_rst;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_drain_el = 0; m_rst_el = 0;
         m_ie = 0; m_err = 0; m_evt = 0; m_tmo = 0; m_irq = 0;
      end else begin
         in_rst = (m_st == 3);
         w_cmd  = reg_we && reg_addr == A_CMD && !in_rst;
         w_sts  = reg_we && reg_addr == A_STS && !in_rst;
         w_rgo  = w_cmd && reg_wdata[1] && m_st == 0;
         w_rbad = w_cmd && reg_wdata[1] && m_st != 0;
         w_to   = (m_st == 2) && !(drain_done || !pend_work) && (m_drain_el + 1 == TMO);
         m_irq  = !in_rst && !w_rgo && m_ie && m_evt && thresh;
         if (w_rgo || in_rst) begin
            m_err = 0; m_evt = 0; m_tmo = 0; m_ie = 0;
         end else begin
            m_err = w_rbad ? 1'b1 : ((w_sts && reg_wdata[1]) ? 1'b0 : m_err);
            m_evt = evt_in ? 1'b1 : ((w_sts && reg_wdata[2]) ? 1'b0 : m_evt);
            m_tmo = w_to   ? 1'b1 : ((w_sts && reg_wdata[3]) ? 1'b0 : m_tmo);
            if (w_cmd) m_ie = reg_wdata[2];
         end
         case (m_st)
            0: if (w_rgo) begin m_st = 3; m_rst_el = 0; end
               else if (w_cmd && reg_wdata[0]) m_st = 1;
            1: if (w_cmd && !reg_wdata[0]) begin m_st = 2; m_drain_el = 0; end
            2: begin
               m_drain_el++;
               if (drain_done || !pend_work || m_drain_el == TMO) m_st = 0;
            end
            default: begin
               m_rst_el++;
               if (m_rst_el == RST) m_st = 0;
            end
         endcase
      end
   end

   // compare against the model on every falling edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(tag, "halted", int'(halted), int'(m_st == 0));
         chk(tag, "ctrl_rst", int'(ctrl_rst), int'(m_st == 3));
         chk(tag, "irq", int'(irq), int'(m_irq));
         chk(tag, "cmd", int'(cmd_rdata),
             (m_st == 1 ? 1 : 0) | (m_st == 3 ? 2 : 0) | (m_ie ? 4 : 0));
         chk(tag, "sts", int'(sts_rdata),
             (m_st == 0 ? 1 : 0) | (m_err ? 2 : 0) | (m_evt ? 4 : 0) | (m_tmo ? 8 : 0));
      end
   end

   // one write, sampled at the next rising edge; call at a falling edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "halted", int'(halted), 1);
      chk("R1", "cmd", int'(cmd_rdata), 0);
      chk("R1", "sts", int'(sts_rdata), 1);
      chk("R1", "irq/ctrl_rst", int'({irq, ctrl_rst}), 0);

      // R9 enabled interrupt at a threshold
      tag = "R9";
      wr(A_CMD, 32'h4);
      evt_in = 1'b1; @(negedge clk); evt_in = 1'b0;
      chk("R8", "evt bit set", int'(sts_rdata[2]), 1);
      thresh = 1'b1; @(negedge clk); thresh = 1'b0;
      chk("R9", "irq pulse", int'(irq), 1);
      @(negedge clk);
      chk("R9", "irq one cycle", int'(irq), 0);

      // R8 write 0 keeps, write 1 clears, bit 0 not writable
      tag = "R8";
      wr(A_STS, 32'h0);
      chk("R8", "write 0 keeps", int'(sts_rdata), 5);
      wr(A_STS, 32'h5);
      chk("R8", "write 1 clears", int'(sts_rdata), 1);

      // R9 disabled interrupt
      tag = "R9";
      wr(A_CMD, 32'h0);
      evt_in = 1'b1; @(negedge clk); evt_in = 1'b0;
      thresh = 1'b1; @(negedge clk); thresh = 1'b0;
      chk("R9", "no irq when disabled", int'(irq), 0);
      wr(A_STS, 32'h4);

      // R2 run from halted
      tag = "R2";
      wr(A_CMD, 32'h1);
      chk("R2", "running halted", int'(halted), 0);
      chk("R2", "run bit", int'(cmd_rdata[0]), 1);

      // R10 run again while running
      tag = "R10";
      wr(A_CMD, 32'h1);
      chk("R10", "still running", int'(cmd_rdata), 1);

      // R7 illegal reset while running
      tag = "R7";
      wr(A_CMD, 32'h3);
      chk("R7", "no reset", int'(ctrl_rst), 0);
      chk("R7", "error bit", int'(sts_rdata[1]), 1);
      chk("R7", "run kept", int'(cmd_rdata[0]), 1);

      // R3 stop with queued work, then drain completes
      tag = "R3";
      pend_work = 1'b1; drain_done = 1'b0;
      wr(A_CMD, 32'h0);
      chk("R3", "draining not halted", int'(halted), 0);
      chk("R3", "run bit clear", int'(cmd_rdata[0]), 0);
      tag = "R2";
      wr(A_CMD, 32'h1);
      chk("R2", "run ignored in drain", int'(cmd_rdata[0]), 0);
      idle(3);
      tag = "R3";
      drain_done = 1'b1; @(negedge clk); drain_done = 1'b0;
      chk("R3", "halted after drain", int'(halted), 1);
      wr(A_STS, 32'h2);

      // R4 forced halt after the timeout window
      tag = "R4";
      wr(A_CMD, 32'h1);
      wr(A_CMD, 32'h0);
      idle(TMO - 1);
      chk("R4", "not yet halted", int'(halted), 0);
      @(negedge clk);
      chk("R4", "forced halt", int'(halted), 1);
      chk("R4", "timeout bit", int'(sts_rdata[3]), 1);
      tag = "R8";
      wr(A_STS, 32'h8);
      chk("R8", "timeout cleared", int'(sts_rdata), 1);

      // R3 stop with no pending work halts at once
      tag = "R3";
      pend_work = 1'b0;
      wr(A_CMD, 32'h1);
      wr(A_CMD, 32'h0);
      idle(1);
      chk("R3", "immediate halt", int'(halted), 1);
      pend_work = 1'b1;

      // R5 / R10 reset with run in the same write
      tag = "R5";
      wr(A_CMD, 32'h4);
      evt_in = 1'b1; @(negedge clk); evt_in = 1'b0;
      wr(A_CMD, 32'h3);
      chk("R10", "reset only", int'(cmd_rdata), 2);
      chk("R5", "ctrl_rst high", int'(ctrl_rst), 1);
      chk("R5", "status cleared", int'(sts_rdata), 0);
      // R6 writes during reset ignored
      tag = "R6";
      wr(A_CMD, 32'h0);
      wr(A_CMD, 32'h5);
      evt_in = 1'b1;
      wr(A_STS, 32'hF);
      evt_in = 1'b0;
      chk("R6", "reset not shortened", int'(cmd_rdata), 2);
      tag = "R5";
      idle(RST - 4);
      chk("R5", "reset still held", int'(ctrl_rst), 1);
      @(negedge clk);
      chk("R5", "halted after reset", int'(halted), 1);
      chk("R5", "cmd after reset", int'(cmd_rdata), 0);

      // R8 event arriving with its clearing write
      tag = "R8";
      evt_in = 1'b1; @(negedge clk);
      reg_we = 1'b1; reg_addr = A_STS; reg_wdata = 32'h4;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0; evt_in = 1'b0;
      chk("R8", "set wins", int'(sts_rdata[2]), 1);
      wr(A_STS, 32'h4);
      chk("R8", "cleared after", int'(sts_rdata[2]), 0);

      idle(2);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         finish_run();
      end
   end

endmodule